// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns the fields of the instruction being executed into the steering and write-enable signals of a single-cycle processor datapath. It reads the 6-bit major opcode, the 6-bit function field of register-register instructions, and the zero flag returned by the ALU. From these it produces the register-file, memory, operand-select and branch controls, plus a 3-bit ALU operation code.

The decoder is flat. One pass produces the final ALU operation from the opcode and the function field together, and the same pass gates the branch select with the zero flag. There is no intermediate two-level ALU-control encoding. The supported set is five register-register operations (add, subtract, and, or, set-less-than), a word load, a word store and a branch-if-equal. Any other encoding gives a safe output set that writes neither a register nor memory and does not redirect the program counter.

The logic is purely combinational, so the outputs follow the inputs within the same cycle.

Top module: `sc_ctrl_decoder`

## Requirements
- R1: With opcode 000000, function codes 100000, 100010, 100100, 100101 and 101010 give ALU operation 010, 110, 000, 001 and 111 respectively.
- R2: A recognised register-register instruction drives reg_dst=1 and reg_we=1, with alu_imm=0, mem_to_reg=0, mem_rd=0, mem_we=0 and pc_branch=0.
- R3: Opcode 100011 (load) drives alu_imm=1, mem_rd=1, mem_to_reg=1, reg_we=1, reg_dst=0, mem_we=0 and ALU operation 010.
- R4: Opcode 101011 (store) drives alu_imm=1, mem_we=1, ALU operation 010, and keeps reg_we, mem_rd, mem_to_reg and reg_dst at 0.
- R5: Opcode 000100 (branch-if-equal) drives ALU operation 110 and keeps reg_we, alu_imm, mem_rd, mem_we and mem_to_reg at 0.
- R6: pc_branch is 1 exactly when the opcode is 000100 and alu_zero is 1. alu_zero has no effect on any output for other opcodes.
- R7: For any opcode other than the four above, every output is 0 except alu_op, which is 010.
- R8: For opcode 000000 with a function code outside the five listed in R1, every output is 0 except alu_op, which is 010.
- R9: mem_rd and mem_we are never 1 together, and alu_imm is 1 only while one of them is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 6 | Major opcode of the current instruction |
| fn_code | input | 6 | Function field, used only for register-register instructions |
| alu_zero | input | 1 | Zero flag from the ALU result |
| reg_dst | output | 1 | 1 selects the third register field as write destination |
| alu_imm | output | 1 | 1 selects the sign-extended immediate as second ALU operand |
| mem_to_reg | output | 1 | 1 writes memory read data back instead of the ALU result |
| reg_we | output | 1 | Register-file write enable |
| mem_rd | output | 1 | Data memory read enable |
| mem_we | output | 1 | Data memory write enable |
| alu_op | output | 3 | ALU operation code |
| pc_branch | output | 1 | 1 loads the branch target into the program counter |

## Verification
Each of the five register-register function codes is applied under opcode 000000 to separate the ALU-code mapping from the shared control pattern. The load, store and branch opcodes are each applied with alu_zero at both levels. This shows that only the branch reacts to the flag and that the immediate and memory selects follow the memory opcodes. Every other opcode value is swept, and so is every other function code under opcode 000000, to show that unrecognised encodings fall to the safe set and that near-miss codes one bit away from a valid one are not accepted.

// File: rtl/sc_ctrl_pkg.sv
// Package: encodings shared by the control decoder and its sub-blocks.
// Assumes a 6-bit opcode, 6-bit function field and 3-bit ALU operation code.
package sc_ctrl_pkg;
    localparam int OP_W    = 6;
    localparam int FN_W    = 6;
    localparam int ALUOP_W = 3;
    localparam int N_FN    = 5;

    localparam logic [OP_W-1:0] OPC_REG   = 6'b000000;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;

    localparam logic [ALUOP_W-1:0] AOP_AND = 3'b000;
    localparam logic [ALUOP_W-1:0] AOP_OR  = 3'b001;
    localparam logic [ALUOP_W-1:0] AOP_ADD = 3'b010;
    localparam logic [ALUOP_W-1:0] AOP_SUB = 3'b110;
    localparam logic [ALUOP_W-1:0] AOP_SLT = 3'b111;

    // Function codes and their ALU operations; entry 0 is add.
    localparam logic [N_FN-1:0][FN_W-1:0] FN_TAB =
        {6'b101010, 6'b100101, 6'b100100, 6'b100010, 6'b100000};
    localparam logic [N_FN-1:0][ALUOP_W-1:0] AOP_TAB =
        {AOP_SLT, AOP_OR, AOP_AND, AOP_SUB, AOP_ADD};

    typedef enum logic [2:0] {
        CL_NONE  = 3'd0,
        CL_REG   = 3'd1,
        CL_LOAD  = 3'd2,
        CL_STORE = 3'd3,
        CL_BEQ   = 3'd4
    } instr_class_e;
endpackage

// File: rtl/sc_op_class.sv
// Module: classifies the major opcode into one instruction class.
// Assumes: purely combinational; unknown opcodes map to CL_NONE.
module sc_op_class
    import sc_ctrl_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output instr_class_e    cls
);
    // Opcode to class lookup.
    always_comb begin
        case (op_code)
            OPC_REG:   cls = CL_REG;
            OPC_LOAD:  cls = CL_LOAD;
            OPC_STORE: cls = CL_STORE;
            OPC_BEQ:   cls = CL_BEQ;
            default:   cls = CL_NONE;
        endcase
    end
endmodule

// File: rtl/sc_alu_sel.sv
// Module: picks the final ALU operation from class and function field.
// Assumes: fn_code is meaningful only for CL_REG; fn_ok flags a known code.
module sc_alu_sel
    import sc_ctrl_pkg::*;
(
    input  instr_class_e       cls,
    input  logic [FN_W-1:0]    fn_code,
    output logic [ALUOP_W-1:0] alu_op,
    output logic               fn_ok
);
    logic [N_FN-1:0]    hit;
    logic [ALUOP_W-1:0] fn_aop;

    // One comparator per supported function code.
    for (genvar g = 0; g < N_FN; g++) begin : g_fn_match
        assign hit[g] = (fn_code == FN_TAB[g]);
    end

    // OR together the ALU code of whichever entry matched.
    always_comb begin
        fn_aop = '0;
        for (int i = 0; i < N_FN; i++) begin
            if (hit[i]) fn_aop = fn_aop | AOP_TAB[i];
        end
    end

    // Final ALU operation; add is the default for every non-arithmetic case.
    always_comb begin
        fn_ok = |hit;
        case (cls)
            CL_REG:  alu_op = fn_ok ? fn_aop : AOP_ADD;
            CL_BEQ:  alu_op = AOP_SUB;
            default: alu_op = AOP_ADD;
        endcase
    end
endmodule

// File: rtl/sc_ctrl_decoder.sv
// Module: flat single-cycle control decoder (top).
// Assumes: combinational; the clocked datapath samples the outputs.
// Unrecognised encodings yield no register write, no memory access, no branch.
module sc_ctrl_decoder
    import sc_ctrl_pkg::*;
(
    input  logic [OP_W-1:0]    op_code,
    input  logic [FN_W-1:0]    fn_code,
    input  logic               alu_zero,
    output logic               reg_dst,
    output logic               alu_imm,
    output logic               mem_to_reg,
    output logic               reg_we,
    output logic               mem_rd,
    output logic               mem_we,
    output logic [ALUOP_W-1:0] alu_op,
    output logic               pc_branch
);
    instr_class_e cls;
    logic         fn_ok;

    sc_op_class u_class (
        .op_code (op_code),
        .cls     (cls)
    );

    sc_alu_sel u_alu_sel (
        .cls     (cls),
        .fn_code (fn_code),
        .alu_op  (alu_op),
        .fn_ok   (fn_ok)
    );

    // Datapath steering and enables per instruction class.
    always_comb begin
        reg_dst    = 1'b0;
        alu_imm    = 1'b0;
        mem_to_reg = 1'b0;
        reg_we     = 1'b0;
        mem_rd     = 1'b0;
        mem_we     = 1'b0;
        pc_branch  = 1'b0;
        case (cls)
            CL_REG: begin
                reg_dst = fn_ok;
                reg_we  = fn_ok;
            end
            CL_LOAD: begin
                alu_imm    = 1'b1;
                mem_to_reg = 1'b1;
                reg_we     = 1'b1;
                mem_rd     = 1'b1;
            end
            CL_STORE: begin
                alu_imm = 1'b1;
                mem_we  = 1'b1;
            end
            CL_BEQ: pc_branch = alu_zero;
            default: ;
        endcase
    end

    // Cross-checks between the opcode inputs and the assembled controls.
    always_comb begin
        assert_no_dual_mem_R9: assert (!(mem_rd && mem_we));
        assert_imm_needs_mem_R9: assert (!alu_imm || mem_rd || mem_we);
        assert_branch_only_beq_R6: assert (pc_branch == ((op_code == OPC_BEQ) && alu_zero));
        assert_store_no_wb_R4: assert (op_code != OPC_STORE || (!reg_we && alu_op == AOP_ADD));
        assert_beq_sub_R5: assert (op_code != OPC_BEQ || (alu_op == AOP_SUB && !reg_we));
        assert_unknown_safe_R7: assert (cls != CL_NONE || !(reg_we || mem_we || mem_rd || pc_branch));
    end
endmodule

// File: tb/test_sc_ctrl_decoder.sv
// Directed bench for the control decoder; one task per scenario.
module test_sc_ctrl_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] op_code = '0;
    logic [5:0] fn_code = '0;
    logic       alu_zero = 1'b0;
    logic       reg_dst, alu_imm, mem_to_reg, reg_we, mem_rd, mem_we, pc_branch;
    logic [2:0] alu_op;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    sc_ctrl_decoder i_sc_ctrl_decoder (
        .op_code(op_code), .fn_code(fn_code), .alu_zero(alu_zero),
        .reg_dst(reg_dst), .alu_imm(alu_imm), .mem_to_reg(mem_to_reg),
        .reg_we(reg_we), .mem_rd(mem_rd), .mem_we(mem_we),
        .alu_op(alu_op), .pc_branch(pc_branch)
    );

    // Packed view: {reg_dst, alu_imm, mem_to_reg, reg_we, mem_rd, mem_we, alu_op, pc_branch}
    function automatic logic [9:0] pk(logic d, logic i, logic m2r, logic we,
                                      logic rd, logic wr, logic [2:0] op, logic br);
        return {d, i, m2r, we, rd, wr, op, br};
    endfunction

    localparam logic [9:0] SAFE = 10'b0000_00_010_0;

    task automatic apply_and_check(input string req, input logic [5:0] op,
                                   input logic [5:0] fn, input logic z,
                                   input logic [9:0] exp);
        @(posedge clk);
        op_code = op; fn_code = fn; alu_zero = z;
        @(negedge clk);
        n_cmp++;
        if (pk(reg_dst, alu_imm, mem_to_reg, reg_we, mem_rd, mem_we, alu_op, pc_branch) !== exp) begin
            n_bad++;
            $display("FAIL %s op=%b fn=%b z=%b actual=%b expected=%b", req, op, fn, z,
                     pk(reg_dst, alu_imm, mem_to_reg, reg_we, mem_rd, mem_we, alu_op, pc_branch), exp);
        end
    endtask

    // Idle inputs (all zero): R-type with an unknown function code.
    task automatic t_idle;
        apply_and_check("R8 idle", 6'b000000, 6'b000000, 1'b0, SAFE);
    endtask

    // R1/R2: each arithmetic function code, zero flag at both levels.
    task automatic t_rtype;
        for (int z = 0; z < 2; z++) begin
            apply_and_check("R1 R2 add", 6'b000000, 6'b100000, z[0], pk(1,0,0,1,0,0,3'b010,0));
            apply_and_check("R1 R2 sub", 6'b000000, 6'b100010, z[0], pk(1,0,0,1,0,0,3'b110,0));
            apply_and_check("R1 R2 and", 6'b000000, 6'b100100, z[0], pk(1,0,0,1,0,0,3'b000,0));
            apply_and_check("R1 R2 or",  6'b000000, 6'b100101, z[0], pk(1,0,0,1,0,0,3'b001,0));
            apply_and_check("R1 R2 slt", 6'b000000, 6'b101010, z[0], pk(1,0,0,1,0,0,3'b111,0));
        end
    endtask

    // R3/R4/R6: memory opcodes ignore the function field and the zero flag.
    task automatic t_mem;
        for (int z = 0; z < 2; z++) begin
            apply_and_check("R3 R6 load",  6'b100011, 6'b100010, z[0], pk(0,1,1,1,1,0,3'b010,0));
            apply_and_check("R4 R6 store", 6'b101011, 6'b101010, z[0], pk(0,1,0,0,0,1,3'b010,0));
        end
    endtask

    // R5/R6: branch taken only with zero set.
    task automatic t_branch;
        apply_and_check("R5 R6 beq not taken", 6'b000100, 6'b100000, 1'b0, pk(0,0,0,0,0,0,3'b110,0));
        apply_and_check("R5 R6 beq taken",     6'b000100, 6'b100000, 1'b1, pk(0,0,0,0,0,0,3'b110,1));
    endtask

    // R7: every other opcode, both zero levels.
    task automatic t_bad_opcode;
        for (int op = 0; op < 64; op++) begin
            if (op == 6'b000000 || op == 6'b100011 || op == 6'b101011 || op == 6'b000100) continue;
            apply_and_check("R7 unknown opcode", op[5:0], 6'b100000, 1'b1, SAFE);
            apply_and_check("R7 unknown opcode", op[5:0], 6'b101010, 1'b0, SAFE);
        end
    endtask

    // R8: every other function code under the register-register opcode.
    task automatic t_bad_funct;
        for (int fn = 0; fn < 64; fn++) begin
            if (fn == 6'b100000 || fn == 6'b100010 || fn == 6'b100100 ||
                fn == 6'b100101 || fn == 6'b101010) continue;
            apply_and_check("R8 unknown function", 6'b000000, fn[5:0], fn[0], SAFE);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_rtype();
        t_mem();
        t_branch();
        t_bad_opcode();
        t_bad_funct();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule